// File: doc/BRIEF.md
# Nested Exception Priority Arbiter

This block stores the pending, active, enable and priority state of a small processor's exception sources and decides which one the core should take next. Two sources have fixed, very urgent ranks: the non-maskable request (number 2) and the hard fault (number 3). Seven system handlers (numbers 4 to 10) and `NIRQ` external lines (numbers 16 upward) carry a programmable priority of `PW` bits. Lower values are more urgent, and level 0 is the default. Reset itself is the block's reset input, and it outranks everything by construction.

The most urgent enabled pending source is presented on `sel_id_o`. A grouping field divides each settable priority into an upper preemption part and a lower subpriority part. A preemption request is raised only when the winner's preemption part is strictly more urgent than the current execution level. The core confirms entry with `take_ack_i` and reports completion with `ret_i`. The execution level is recomputed from the sources that remain active. A memory-management or bus fault that is disabled, or that is too low in priority to activate, is turned into a hard fault.

Register port (write strobe, 3-bit address, 32-bit data, combinational read):
- 0: enable set. Writing 1 enables the line.
- 1: enable clear. Writing 1 disables the line.
- 2: pending set for external lines.
- 3: pending clear for external lines.
- 4: priority write. Bits [4:0] give the source number and bits [8+PW-1:8] give the level.
- 5: control. Bits [1:0] give the grouping value, bits [5:4] are the fault enables (bit 4 memory-management, bit 5 bus), bit 6 sets the non-maskable request pending, and bits [12:8] set system handlers 6 to 10 pending.
- 6: read-only active mask, indexed by source number.
- 7: read-only pending mask, indexed by source number.

Level code used on `exec_lvl_o`:
- 0: non-maskable request.
- 1: hard fault.
- 2 + (priority >> grouping): a settable source.
- 15: thread level, when nothing is active.

Top module: `exc_prio_arb`

## Requirements
- R1: After reset every enable, priority, pending and active bit is 0, `sel_valid_o` and `preempt_req_o` are 0, and `exec_lvl_o` is 15.
- R2: Writing 1s to address 0 sets enable bits and writing 1s to address 1 clears them. Zero bits change nothing, and reading either address returns the enable state of the external lines in bits [NIRQ-1:0].
- R3: An external line becomes pending on a rising edge of its input, so a level held high does not make it pending again. It takes part in selection only while its enable bit is 1.
- R4: The selected source is the one with the lowest priority value. Among equal values, the lowest source number wins.
- R5: The hard fault (3) outranks every settable source, and the non-maskable request (2) outranks the hard fault.
- R6: `preempt_req_o` is 1 only when the winner's preemption level is strictly lower than `exec_lvl_o`. The grouping value g makes priority >> g the preemption part.
- R7: `take_ack_i` while `preempt_req_o` is 1 marks the winner active and clears its pending bit. `exec_lvl_o` then becomes the winner's level.
- R8: `ret_i` clears the active bit of `ret_id_i`. The execution level becomes the most urgent level among the sources still active, or 15 when none remains.
- R9: The non-maskable request becomes pending only through control bit 6. While it is active, `preempt_req_o` stays 0.
- R10: A fault request (bit 0 memory-management, bit 1 bus) whose enable is 0, or whose level is not below `exec_lvl_o`, sets the hard fault pending instead of its own bit.
- R11: Writing 1s to address 3 removes pending external lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_i | input | NIRQ | External interrupt lines |
| hf_req_i | input | 1 | Direct hard fault request pulse |
| flt_req_i | input | 2 | Configurable fault request pulses (0 memory-management, 1 bus) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| take_ack_i | input | 1 | Core takes the selected exception |
| ret_i | input | 1 | Core returns from an exception |
| ret_id_i | input | IDW | Number of the returning exception |
| sel_valid_o | output | 1 | An enabled source is pending |
| sel_id_o | output | IDW | Number of the selected source |
| preempt_req_o | output | 1 | Selected source may preempt |
| exec_lvl_o | output | LW | Current execution level |

## Verification
On every cycle the assertions check several properties. An input edge on a line always makes that line pending. The selected source is never outranked by another requester, and equal-priority ties go to the lower number. A take always marks the winner active, and a return from the last active source restores thread level. An active non-maskable request always holds off preemption. Blocked fault requests always end up as a pending hard fault, and cleared enables stay clear. Other behaviour only shows across the directed scenarios: the preemption decision changing as the grouping value moves, the unwinding of nested entries through several returns, and the precise values read back after write-1 register operations.

// File: rtl/eparb_pkg.sv
package eparb_pkg;
    localparam int NMI_ID   = 2;
    localparam int HF_ID    = 3;
    localparam int MM_ID    = 4;
    localparam int BF_ID    = 5;
    localparam int SYS_LO   = 4;
    localparam int SYS_SW   = 6;
    localparam int SYS_HI   = 10;
    localparam int IRQ_BASE = 16;

    typedef enum logic [2:0] {
        A_SETEN  = 3'd0,
        A_CLREN  = 3'd1,
        A_SETPND = 3'd2,
        A_CLRPND = 3'd3,
        A_PRIO   = 3'd4,
        A_CTRL   = 3'd5,
        A_ACT    = 3'd6,
        A_PND    = 3'd7
    } addr_e;

    function automatic logic is_settable(int s, int nirq);
        return (s >= SYS_LO && s <= SYS_HI) || (s >= IRQ_BASE && s < IRQ_BASE + nirq);
    endfunction
endpackage

// File: rtl/eparb_regs.sv
module eparb_regs
    import eparb_pkg::*;
#(
    parameter int NIRQ  = 14,
    parameter int PW    = 3,
    parameter int NSLOT = 30,
    parameter int IDW   = 5,
    parameter int GW    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [2:0]                waddr_i,
    input  logic [31:0]               wdata_i,
    output logic [NIRQ-1:0]           en_o,
    output logic [NSLOT-1:0][PW-1:0]  pri_o,
    output logic [GW-1:0]             grp_o,
    output logic [1:0]                fen_o
);
    typedef struct packed {
        logic [NIRQ-1:0]          en;
        logic [NSLOT-1:0][PW-1:0] pri;
        logic [GW-1:0]            grp;
        logic [1:0]               fen;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (addr_e'(waddr_i))
                A_SETEN: st_d.en = st_q.en | wdata_i[NIRQ-1:0];
                A_CLREN: st_d.en = st_q.en & ~wdata_i[NIRQ-1:0];
                A_PRIO: begin
                    for (int s = 0; s < NSLOT; s++) begin
                        if (is_settable(s, NIRQ) && wdata_i[IDW-1:0] == IDW'(s))
                            st_d.pri[s] = wdata_i[8 +: PW];
                    end
                end
                A_CTRL: begin
                    st_d.grp = wdata_i[GW-1:0];
                    st_d.fen = wdata_i[5:4];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign pri_o = st_q.pri;
    assign grp_o = st_q.grp;
    assign fen_o = st_q.fen;

    // R2
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && waddr_i == A_CLREN) |=> ((st_q.en & $past(wdata_i[NIRQ-1:0])) == '0));

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && waddr_i == A_SETEN) |=> ((st_q.en & $past(wdata_i[NIRQ-1:0])) == $past(wdata_i[NIRQ-1:0])));
endmodule

// File: rtl/eparb_pick.sv
module eparb_pick #(
    parameter int NSLOT = 30,
    parameter int IDW   = 5,
    parameter int LW    = 4
) (
    input  logic [NSLOT-1:0]          req_i,
    input  logic [NSLOT-1:0][LW-1:0]  key_i,
    output logic                      valid_o,
    output logic [IDW-1:0]            id_o
);
    logic [LW-1:0] best;

    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        best    = '1;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (req_i[s] && (!valid_o || key_i[s] <= best)) begin
                valid_o = 1'b1;
                id_o    = IDW'(s);
                best    = key_i[s];
            end
        end
    end
endmodule

// File: rtl/eparb_state.sv
module eparb_state
    import eparb_pkg::*;
#(
    parameter int NIRQ  = 14,
    parameter int NSLOT = 30,
    parameter int IDW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIRQ-1:0]   irq_i,
    input  logic              wr_en_i,
    input  logic [2:0]        waddr_i,
    input  logic [31:0]       wdata_i,
    input  logic              hf_req_i,
    input  logic [1:0]        flt_req_i,
    input  logic [1:0]        flt_ok_i,
    input  logic              take_i,
    input  logic [IDW-1:0]    win_i,
    input  logic              ret_i,
    input  logic [IDW-1:0]    ret_id_i,
    output logic [NSLOT-1:0]  pend_o,
    output logic [NSLOT-1:0]  act_o
);
    localparam int NSYSW = SYS_HI - SYS_SW + 1;

    typedef struct packed {
        logic [NIRQ-1:0]  irq;
        logic [NSLOT-1:0] pend;
        logic [NSLOT-1:0] act;
    } ev_t;

    ev_t st_d, st_q;
    logic [NSLOT-1:0] set_v, clr_v, act_v;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int k = 0; k < NIRQ; k++) begin
            if (irq_i[k] && !st_q.irq[k]) set_v[IRQ_BASE + k] = 1'b1;
        end
        if (wr_en_i) begin
            case (addr_e'(waddr_i))
                A_SETPND: for (int k = 0; k < NIRQ; k++) begin
                    if (wdata_i[k]) set_v[IRQ_BASE + k] = 1'b1;
                end
                A_CLRPND: for (int k = 0; k < NIRQ; k++) begin
                    if (wdata_i[k]) clr_v[IRQ_BASE + k] = 1'b1;
                end
                A_CTRL: begin
                    if (wdata_i[6]) set_v[NMI_ID] = 1'b1;
                    for (int j = 0; j < NSYSW; j++) begin
                        if (wdata_i[8 + j]) set_v[SYS_SW + j] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (hf_req_i) set_v[HF_ID] = 1'b1;
        for (int k = 0; k < 2; k++) begin
            if (flt_req_i[k]) begin
                if (flt_ok_i[k]) set_v[MM_ID + k] = 1'b1;
                else             set_v[HF_ID]     = 1'b1;
            end
        end
        if (take_i) clr_v[win_i] = 1'b1;

        act_v = st_q.act;
        if (ret_i)  act_v[ret_id_i] = 1'b0;
        if (take_i) act_v[win_i]    = 1'b1;

        st_d.irq  = irq_i;
        st_d.pend = (st_q.pend & ~clr_v) | set_v;
        st_d.act  = act_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;

    // R7
    take_marks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> st_q.act[$past(win_i)]);

    for (genvar k = 0; k < NIRQ; k++) begin : g_edge_chk
        // R3
        edge_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_i[k] && !st_q.irq[k]) |=> st_q.pend[IRQ_BASE + k]);
    end

    for (genvar k = 0; k < 2; k++) begin : g_esc_chk
        // R10
        escalate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_req_i[k] && !flt_ok_i[k]) |=> st_q.pend[HF_ID]);
    end
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import eparb_pkg::*;
#(
    parameter int NIRQ = 14,
    parameter int PW   = 3,
    localparam int NSLOT = IRQ_BASE + NIRQ,
    localparam int IDW   = $clog2(NSLOT),
    localparam int GW    = $clog2(PW + 1),
    localparam int LW    = $clog2((1 << PW) + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIRQ-1:0]  irq_i,
    input  logic             hf_req_i,
    input  logic [1:0]       flt_req_i,
    input  logic             reg_wr_i,
    input  logic [2:0]       reg_addr_i,
    input  logic [31:0]      reg_wdata_i,
    output logic [31:0]      reg_rdata_o,
    input  logic             take_ack_i,
    input  logic             ret_i,
    input  logic [IDW-1:0]   ret_id_i,
    output logic             sel_valid_o,
    output logic [IDW-1:0]   sel_id_o,
    output logic             preempt_req_o,
    output logic [LW-1:0]    exec_lvl_o
);
    localparam logic [LW-1:0] THREAD_LVL = '1;

    logic [NIRQ-1:0]          irq_en;
    logic [NSLOT-1:0][PW-1:0] pri;
    logic [GW-1:0]            grp;
    logic [1:0]               fen;
    logic [NSLOT-1:0]         pend, act, en_vec, req;
    logic [NSLOT-1:0][LW-1:0] key, plv;
    logic [LW-1:0]            exec_lvl;
    logic [1:0]               flt_ok;
    logic                     take, win_valid;
    logic [IDW-1:0]           win_id;

    eparb_regs #(.NIRQ(NIRQ), .PW(PW), .NSLOT(NSLOT), .IDW(IDW), .GW(GW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_i), .waddr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .en_o(irq_en), .pri_o(pri), .grp_o(grp), .fen_o(fen)
    );

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            if (s == NMI_ID) begin
                key[s] = LW'(0); plv[s] = LW'(0);
            end else if (s == HF_ID) begin
                key[s] = LW'(1); plv[s] = LW'(1);
            end else begin
                key[s] = LW'(2) + LW'(pri[s]);
                plv[s] = LW'(2) + LW'(pri[s] >> grp);
            end
            if (s == NMI_ID || s == HF_ID)           en_vec[s] = 1'b1;
            else if (s == MM_ID)                     en_vec[s] = fen[0];
            else if (s == BF_ID)                     en_vec[s] = fen[1];
            else if (s >= SYS_SW && s <= SYS_HI)     en_vec[s] = 1'b1;
            else if (s >= IRQ_BASE)                  en_vec[s] = irq_en[s - IRQ_BASE];
            else                                     en_vec[s] = 1'b0;
        end
        req = pend & en_vec;
    end

    always_comb begin
        exec_lvl = THREAD_LVL;
        for (int s = 0; s < NSLOT; s++) begin
            if (act[s] && plv[s] < exec_lvl) exec_lvl = plv[s];
        end
        flt_ok[0] = fen[0] && (plv[MM_ID] < exec_lvl);
        flt_ok[1] = fen[1] && (plv[BF_ID] < exec_lvl);
    end

    eparb_pick #(.NSLOT(NSLOT), .IDW(IDW), .LW(LW)) u_pick (
        .req_i(req), .key_i(key), .valid_o(win_valid), .id_o(win_id)
    );

    assign preempt_req_o = win_valid && (plv[win_id] < exec_lvl);
    assign take          = take_ack_i && preempt_req_o;

    eparb_state #(.NIRQ(NIRQ), .NSLOT(NSLOT), .IDW(IDW)) u_state (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en_i(reg_wr_i),
        .waddr_i(reg_addr_i), .wdata_i(reg_wdata_i), .hf_req_i(hf_req_i),
        .flt_req_i(flt_req_i), .flt_ok_i(flt_ok), .take_i(take), .win_i(win_id),
        .ret_i(ret_i), .ret_id_i(ret_id_i), .pend_o(pend), .act_o(act)
    );

    always_comb begin
        case (addr_e'(reg_addr_i))
            A_SETEN, A_CLREN:   reg_rdata_o = 32'(irq_en);
            A_SETPND, A_CLRPND: reg_rdata_o = 32'(pend[NSLOT-1:IRQ_BASE]);
            A_CTRL:             reg_rdata_o = 32'(grp) | (32'(fen) << 4);
            A_ACT:              reg_rdata_o = 32'(act);
            A_PND:              reg_rdata_o = 32'(pend);
            default:            reg_rdata_o = '0;
        endcase
    end

    assign sel_valid_o = win_valid;
    assign sel_id_o    = win_id;
    assign exec_lvl_o  = exec_lvl;

    // R9
    nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act[NMI_ID] |-> !preempt_req_o);

    // R8
    last_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !take && act == (NSLOT'(1) << ret_id_i)) |=> (exec_lvl_o == THREAD_LVL));

    for (genvar j = 0; j < NSLOT; j++) begin : g_order_chk
        // R4
        tie_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_valid_o && req[j]) |->
                (key[sel_id_o] < key[j]) || (key[sel_id_o] == key[j] && sel_id_o <= IDW'(j)));
    end
endmodule

// File: tb/exc_prio_arb_bench.sv
module exc_prio_arb_bench;
    localparam int CLK_PER = 10;
    localparam int NIRQ = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NIRQ-1:0] irq = '0;
    logic        hf_req = 1'b0;
    logic [1:0]  flt_req = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        take_ack = 1'b0;
    logic        ret = 1'b0;
    logic [4:0]  ret_id = '0;
    logic        sel_valid;
    logic [4:0]  sel_id;
    logic        preempt_req;
    logic [3:0]  exec_lvl;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER / 2) clk = ~clk;

    exc_prio_arb u_exc_prio_arb (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .hf_req_i(hf_req), .flt_req_i(flt_req),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .take_ack_i(take_ack), .ret_i(ret), .ret_id_i(ret_id),
        .sel_valid_o(sel_valid), .sel_id_o(sel_id), .preempt_req_o(preempt_req),
        .exec_lvl_o(exec_lvl)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic setpri(int id, int p);
        wr(3'd4, 32'((p << 8) | id));
    endtask

    task automatic ack();
        take_ack = 1'b1;
        @(negedge clk);
        take_ack = 1'b0;
    endtask

    task automatic do_ret(int id);
        ret = 1'b1; ret_id = 5'(id);
        @(negedge clk);
        ret = 1'b0;
    endtask

    task automatic pulse_irq(logic [NIRQ-1:0] m);
        irq = m;
        @(negedge clk);
        irq = '0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d);  check("R1 enables", d, 0);
        rd(3'd7, d);  check("R1 pending", d, 0);
        rd(3'd6, d);  check("R1 active", d, 0);
        check("R1 sel_valid", 32'(sel_valid), 0);
        check("R1 preempt", 32'(preempt_req), 0);
        check("R1 exec", 32'(exec_lvl), 15);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(3'd0, 32'h5);
        rd(3'd0, d); check("R2 set read", d, 32'h5);
        rd(3'd1, d); check("R2 clr-addr read", d, 32'h5);
        wr(3'd0, 32'h0);
        rd(3'd0, d); check("R2 zero set", d, 32'h5);
        wr(3'd1, 32'h1);
        rd(3'd0, d); check("R2 clear", d, 32'h4);
        wr(3'd1, 32'h0);
        rd(3'd1, d); check("R2 zero clear", d, 32'h4);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        pulse_irq(14'h8);
        rd(3'd2, d); check("R3 pending on edge", d, 32'h8);
        check("R3 disabled not selected", 32'(sel_valid), 0);
        wr(3'd0, 32'h8);
        check("R3 enabled selected", 32'(sel_valid), 1);
        check("R3 sel id", 32'(sel_id), 19);
        wr(3'd3, 32'h8);
        check("R11 clear pending", 32'(sel_valid), 0);
        irq[3] = 1'b1;
        @(negedge clk);
        check("R3 rise pends", 32'(sel_valid), 1);
        wr(3'd3, 32'h8);
        @(negedge clk);
        @(negedge clk);
        check("R3 level no repend", 32'(sel_valid), 0);
        irq[3] = 1'b0;
        @(negedge clk);
        rd(3'd2, d); check("R11 pending read", d, 0);
    endtask

    task automatic t_tie();
        logic [31:0] d;
        wr(3'd0, 32'h220);
        pulse_irq(14'h220);
        check("R4 tie lower number", 32'(sel_id), 21);
        setpri(21, 3);
        check("R4 lower value wins", 32'(sel_id), 25);
        setpri(25, 3);
        check("R4 tie again", 32'(sel_id), 21);
        wr(3'd3, 32'h220);
        rd(3'd7, d); check("R11 tie cleanup", d, 0);
    endtask

    task automatic t_group();
        wr(3'd0, 32'h6);
        setpri(17, 5);
        setpri(18, 4);
        wr(3'd5, 32'h0);
        pulse_irq(14'h2);
        check("R6 idle preempt", 32'(preempt_req), 1);
        ack();
        check("R7 exec after take", 32'(exec_lvl), 7);
        pulse_irq(14'h4);
        check("R6 sel", 32'(sel_id), 18);
        check("R6 grp0 preempt", 32'(preempt_req), 1);
        wr(3'd5, 32'h1);
        check("R6 grp1 exec", 32'(exec_lvl), 4);
        check("R6 grp1 no preempt", 32'(preempt_req), 0);
        wr(3'd5, 32'h3);
        check("R6 grp3 no preempt", 32'(preempt_req), 0);
        wr(3'd5, 32'h0);
        check("R6 grp0 again", 32'(preempt_req), 1);
        wr(3'd3, 32'h4);
        do_ret(17);
        check("R8 back to thread", 32'(exec_lvl), 15);
    endtask

    task automatic t_fault();
        logic [31:0] d;
        flt_req = 2'b01; @(negedge clk); flt_req = '0;
        check("R10 disabled escalates", 32'(sel_id), 3);
        rd(3'd7, d); check("R10 pend mask", d & 32'h38, 32'h8);
        ack(); do_ret(3);
        wr(3'd5, 32'h10);
        setpri(4, 2);
        flt_req = 2'b01; @(negedge clk); flt_req = '0;
        check("R10 enabled fault own", 32'(sel_id), 4);
        ack();
        check("R10 fault exec", 32'(exec_lvl), 4);
        wr(3'd5, 32'h30);
        setpri(5, 5);
        flt_req = 2'b10; @(negedge clk); flt_req = '0;
        check("R10 blocked escalates", 32'(sel_id), 3);
        check("R10 hf preempts", 32'(preempt_req), 1);
        rd(3'd7, d); check("R10 bus not pending", d & 32'h20, 0);
        ack(); do_ret(3);
        check("R8 nested unwind", 32'(exec_lvl), 4);
        do_ret(4);
        check("R8 thread", 32'(exec_lvl), 15);
    endtask

    task automatic t_nmi();
        logic [31:0] d;
        wr(3'd0, 32'h1);
        setpri(16, 0);
        pulse_irq(14'h1);
        check("R5 irq alone", 32'(sel_id), 16);
        hf_req = 1'b1; @(negedge clk); hf_req = 1'b0;
        check("R5 hf over settable", 32'(sel_id), 3);
        wr(3'd5, 32'h70);
        check("R5 nmi over hf", 32'(sel_id), 2);
        ack();
        check("R9 nmi exec", 32'(exec_lvl), 0);
        check("R9 nmi not preempted", 32'(preempt_req), 0);
        rd(3'd7, d); check("R7 nmi pend cleared", d, 32'h10008);
        do_ret(2);
        check("R8 after nmi", 32'(exec_lvl), 15);
        ack();
        check("R7 hf exec", 32'(exec_lvl), 1);
        check("R6 irq blocked by hf", 32'(preempt_req), 0);
        do_ret(3);
        ack();
        check("R7 irq exec", 32'(exec_lvl), 2);
        do_ret(16);
        check("R8 final thread", 32'(exec_lvl), 15);
        check("R8 nothing left", 32'(sel_valid), 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=timeout exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        t_enable();
        t_edge();
        t_tie();
        t_group();
        t_fault();
        t_nmi();
        finish_run();
    end
endmodule